// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog built around one byte-wide configuration register. The count runs on a 16 Hz tick input, so each unit of timeout is a sixteenth of a second. Software arms the watchdog by writing the configuration byte. It services the watchdog by writing that byte again or by reading it back. Either access starts the count again from the full timeout.

If the count runs out before it is serviced, the block latches a watchdog flag in a read-only flags register. It then acts according to a steering bit in the configuration byte. With the steering bit set, it raises a one-cycle reset request toward the system reset logic, raises a one-cycle strobe that clears the century bit in the clock block, and zeroes its own configuration. With the steering bit clear, it raises a one-cycle interrupt instead and keeps its configuration.

After an expiry the block stays idle until software services it again. The system reset logic itself lies outside this block.

Top module: `wdog_timer`

## Requirements
- R1: The configuration byte holds a multiplier in bits [6:2] and a resolution in bits [1:0]. The timeout is multiplier × 4^resolution ticks. Expiry takes effect on the tick that completes that count, counted from the last restart, and not earlier.
- R2: When bit 7 (steering) of the configuration is 1 at expiry, `rst_req` and `century_clr` each pulse high for exactly one cycle and `irq` stays low. Afterwards the configuration register reads 0x00.
- R3: When bit 7 of the configuration is 0 at expiry, `irq` pulses high for exactly one cycle, `rst_req` and `century_clr` stay low, and the configuration register keeps its value.
- R4: Every expiry sets the watchdog flag, which is bit 7 of the flags register (`reg_sel`=1). All other bits of the flags register read as 0.
- R5: A write to the configuration register (`reg_sel`=0) stores the byte, restarts the count from the new timeout, and clears the watchdog flag.
- R6: Writing 0x00, or any byte whose multiplier field is 0, disables the watchdog: no expiry occurs however many ticks arrive.
- R7: A read strobe on the configuration register restarts the count from the stored setting and clears the watchdog flag.
- R8: Writes with `reg_sel`=1 have no effect: the flags register keeps its value.
- R9: After `rst_n` is asserted, the configuration is 0x00, the flag is 0, the count is idle, and all three event outputs are low.
- R10: A single arming produces at most one expiry. Further ticks after an expiry produce no event until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 configuration, 1 flags |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| tick_16 | input | 1 | One-cycle pulse at 16 Hz |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |
| century_clr | output | 1 | One-cycle strobe clearing the century bit in the clock block |

## Verification
The assertions check several properties on every cycle:
- The event outputs are single-cycle pulses and are never raised together.
- The century strobe accompanies every reset request.
- An idle or just-restarted counter never expires.
- Every expiry not masked by a software access leaves the flag set.
- A reset-steered expiry leaves the configuration at zero.

Some behaviours can only be shown by the bench's scenarios:
- The exact tick on which each timeout lands for different multiplier and resolution codes.
- That a service access in mid-count pushes the expiry out by a full period.
- That zero settings never fire.
- That writes to the flags register are ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int MULT_LSB = RES_W;
  localparam int STEER_BIT = MULT_LSB + MULT_W;
  localparam int CFG_W  = STEER_BIT + 1;
  localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

  typedef logic [CNT_W-1:0] wd_count_t;
  typedef logic [CFG_W-1:0] wd_cfg_t;

  // timeout in 1/16 s: multiplier shifted left by two bits per resolution step
  function automatic wd_count_t wd_timeout(input wd_cfg_t cfg);
    wd_count_t m;
    m = wd_count_t'(cfg[MULT_LSB +: MULT_W]);
    return m << (2 * cfg[RES_W-1:0]);
  endfunction

  function automatic logic wd_steer(input wd_cfg_t cfg);
    return cfg[STEER_BIT];
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reg_sel,
  input  logic      reg_wr,
  input  logic      reg_rd,
  input  wd_cfg_t   reg_wdata,
  input  logic      expire,
  output wd_cfg_t   reg_rdata,
  output wd_cfg_t   cfg_q,
  output logic      flag_q,
  output logic      load,
  output wd_count_t load_val
);
  logic cfg_wr;
  logic cfg_access;

  assign cfg_wr     = reg_wr & ~reg_sel;
  assign cfg_access = (reg_wr | reg_rd) & ~reg_sel;
  assign load       = cfg_access;
  assign load_val   = cfg_wr ? wd_timeout(reg_wdata) : wd_timeout(cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cfg_wr)
        cfg_q <= reg_wdata;
      else if (expire && wd_steer(cfg_q))
        cfg_q <= '0;
      if (cfg_access)
        flag_q <= 1'b0;
      else if (expire)
        flag_q <= 1'b1;
    end
  end

  assign reg_rdata = reg_sel ? {flag_q, {(CFG_W-1){1'b0}}} : cfg_q;

  // flags register is never changed by a write aimed at it
  assert_flags_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !expire && !reg_rd) |=> $stable(flag_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  wd_count_t load_val,
  output logic      expire
);
  wd_count_t cnt_q;
  logic      armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt_q   <= load_val;
        armed_q <= |load_val;
      end else if (armed_q && tick) begin
        if (cnt_q == wd_count_t'(1)) begin
          armed_q <= 1'b0;
          expire  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !expire);
  assert_restart_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expire);
  assert_zero_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !armed_q);
endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  output logic rst_req,
  output logic irq,
  output logic century_clr
);
  assign rst_req     = expire & steer;
  assign century_clr = expire & steer;
  assign irq         = expire & ~steer;

  assert_rst_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_century_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    century_clr |-> rst_req);
  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && rst_req));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick_16,
  output logic       rst_req,
  output logic       irq,
  output logic       century_clr
);
  wd_cfg_t   cfg_q;
  logic      flag_q;
  logic      load;
  wd_count_t load_val;
  logic      expire;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .expire(expire),
    .reg_rdata(reg_rdata), .cfg_q(cfg_q), .flag_q(flag_q),
    .load(load), .load_val(load_val)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_16), .load(load),
    .load_val(load_val), .expire(expire)
  );

  wdog_action u_act (
    .clk(clk), .rst_n(rst_n), .expire(expire), .steer(wd_steer(cfg_q)),
    .rst_req(rst_req), .irq(irq), .century_clr(century_clr)
  );

  assert_flag_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !((reg_wr || reg_rd) && !reg_sel)) |=> flag_q);
  assert_cfg_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !(reg_wr && !reg_sel)) |=> (cfg_q == '0));
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tick_16 = 1'b0;
  logic       rst_req, irq, century_clr;

  int checks = 0;
  int errors = 0;
  int n_irq = 0, n_rst = 0, n_cen = 0;

  always #5 clk = ~clk;

  wdog_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_16(tick_16), .rst_req(rst_req), .irq(irq), .century_clr(century_clr)
  );

  always @(negedge clk) begin
    if (irq) n_irq++;
    if (rst_req) n_rst++;
    if (century_clr) n_cen++;
  end

  localparam int NVEC = 6;
  localparam logic [7:0] VEC_CFG [0:NVEC-1] =
    '{8'h04, 8'h09, 8'h0E, 8'h17, 8'h8A, 8'h7F};
  localparam int VEC_TICKS [0:NVEC-1] = '{1, 8, 48, 320, 32, 1984};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_cfg();
    @(negedge clk);
    reg_sel = 1'b0; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_16 = 1'b1;
      @(negedge clk);
      tick_16 = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic peek(input logic sel, output logic [7:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic clr_counts();
    n_irq = 0; n_rst = 0; n_cen = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int exp_t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    peek(1'b0, v); check(v == 8'h00, "R9 cfg after reset", v, 0);
    peek(1'b1, v); check(v == 8'h00, "R9 flags after reset", v, 0);
    check(!irq && !rst_req && !century_clr, "R9 outputs low", {irq, rst_req, century_clr}, 0);
    clr_counts(); ticks(20);
    check(n_irq + n_rst + n_cen == 0, "R9 idle after reset", n_irq + n_rst, 0);

    // R8 flags register write ignored while clear
    wr_reg(1'b1, 8'hFF);
    peek(1'b1, v); check(v == 8'h00, "R8 flags write ignored", v, 0);

    // R1/R2/R3/R4/R10 table walk
    for (int k = 0; k < NVEC; k++) begin
      exp_t = (VEC_CFG[k][6:2]);
      for (int r = 0; r < VEC_CFG[k][1:0]; r++) exp_t = exp_t * 4;
      check(exp_t == VEC_TICKS[k], "R1 table consistency", exp_t, VEC_TICKS[k]);
      clr_counts();
      wr_reg(1'b0, VEC_CFG[k]);
      ticks(VEC_TICKS[k] - 1);
      check(n_irq + n_rst == 0, "R1 no early expiry", n_irq + n_rst, 0);
      ticks(1);
      @(negedge clk);
      if (VEC_CFG[k][7]) begin
        check(n_rst == 1 && n_cen == 1 && n_irq == 0, "R2 reset steered events",
              {n_rst[3:0], n_cen[3:0], n_irq[3:0]}, 12'h110);
        peek(1'b0, v); check(v == 8'h00, "R2 cfg cleared", v, 0);
      end else begin
        check(n_irq == 1 && n_rst == 0 && n_cen == 0, "R3 interrupt steered events",
              {n_irq[3:0], n_rst[3:0], n_cen[3:0]}, 12'h100);
        peek(1'b0, v); check(v == VEC_CFG[k], "R3 cfg kept", v, VEC_CFG[k]);
      end
      peek(1'b1, v); check(v == 8'h80, "R4 flag set", v, 8'h80);
      ticks(10);
      check(n_irq + n_rst == 1, "R10 single expiry", n_irq + n_rst, 1);
    end

    // R8 write to flags cannot clear the set flag
    wr_reg(1'b1, 8'h00);
    peek(1'b1, v); check(v == 8'h80, "R8 flag survives write", v, 8'h80);

    // R5 write restarts and clears flag
    clr_counts();
    wr_reg(1'b0, 8'h09);
    peek(1'b1, v); check(v == 8'h00, "R5 write clears flag", v, 0);
    ticks(5);
    wr_reg(1'b0, 8'h09);
    ticks(7);
    check(n_irq == 0, "R5 restart by write delays expiry", n_irq, 0);
    ticks(1); @(negedge clk);
    check(n_irq == 1, "R5 expiry after full period", n_irq, 1);

    // R7 read restarts and clears flag
    clr_counts();
    peek(1'b1, v); check(v == 8'h80, "R7 flag set before read", v, 8'h80);
    rd_cfg();
    peek(1'b1, v); check(v == 8'h00, "R7 read clears flag", v, 0);
    ticks(5);
    check(n_irq == 0, "R7 read rearmed no early", n_irq, 0);
    rd_cfg();
    ticks(7);
    check(n_irq == 0, "R7 restart by read delays expiry", n_irq, 0);
    ticks(1); @(negedge clk);
    check(n_irq == 1, "R7 expiry after read restart", n_irq, 1);

    // R6 zero disables
    clr_counts();
    wr_reg(1'b0, 8'h0D);
    ticks(3);
    wr_reg(1'b0, 8'h00);
    ticks(100);
    check(n_irq + n_rst == 0, "R6 zero write stops", n_irq + n_rst, 0);
    wr_reg(1'b0, 8'h83);
    ticks(100);
    check(n_irq + n_rst + n_cen == 0, "R6 zero multiplier disabled", n_irq + n_rst, 0);

    // R9 reset mid-count
    clr_counts();
    wr_reg(1'b0, 8'h85);
    ticks(2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ticks(10);
    check(n_rst + n_irq == 0, "R9 reset returns to idle", n_rst + n_irq, 0);
    peek(1'b0, v); check(v == 8'h00, "R9 cfg zero after reset", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule